// File: doc/BRIEF.md
# ADC Result Register Interlock

This block holds the result of a 10-bit successive-approximation converter and presents it to an 8-bit CPU bus as two bytes, an upper byte and a lower byte. When a conversion finishes, the block takes in the new result on the completion strobe. It then formats the result for the CPU according to the selected resolution.

In 10-bit mode the block keeps the two bytes coherent. Once the CPU reads the upper byte, the held result is frozen until the CPU reads the lower byte. Any conversion that finishes during that window is thrown away, not queued, and a sticky overrun flag records the loss. In 8-bit mode the freeze never applies: every completion replaces the held value, and the lower byte carries the eight most significant result bits.

The read strobes are single-cycle pulses that the bus decoder raises whenever the CPU reads the corresponding byte. The output bytes are combinational views of the held result, so a read in a given cycle sees the value held in that cycle.

Top module: `adc_result_hold`

## Requirements
- R1: When `convDone` is high and the lock is clear, `convData` is captured and is visible on the outputs from the next cycle.
- R2: A `rdHigh` pulse with `wideMode`=1 and `rdLow`=0 sets the lock from the next cycle.
- R3: A `convDone` that arrives while the lock is set and `wideMode`=1, with no `rdLow` in the same cycle, is discarded, and `highByte` and `lowByte` keep their values.
- R4: A `rdLow` pulse clears the lock from the next cycle. This also holds when `rdHigh` is high in the same cycle.
- R5: While `wideMode`=0 the lock is held clear, and every `convDone` loads the result whatever the order of reads.
- R6: `overrun` becomes 1 in the cycle after a discard (R3). It stays 1 until a `rdLow` pulse, which makes it 0 from the next cycle.
- R7: When `rdLow` and `convDone` are high in the same cycle, the lock is released first and the new result is loaded.
- R8: With `wideMode`=1, `highByte` = {6'b000000, result[9:8]} and `lowByte` = result[7:0].
- R9: With `wideMode`=0, `highByte` = 8'h00 and `lowByte` = result[9:2].
- R10: After reset the held result is zero, the lock is clear and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convDone | input | 1 | Conversion-complete strobe |
| convData | input | 10 | Result of the finished conversion |
| wideMode | input | 1 | 1 selects 10-bit mode, 0 selects 8-bit mode |
| rdHigh | input | 1 | CPU reads the upper byte this cycle |
| rdLow | input | 1 | CPU reads the lower byte this cycle |
| highByte | output | 8 | Upper result byte |
| lowByte | output | 8 | Lower result byte |
| overrun | output | 1 | Sticky flag: a result was discarded under the lock |

## Verification
On every cycle, the assertions check the following:
- A locked completion leaves the held result unchanged.
- A loading strobe captures exactly the presented data.
- A read of the upper byte in wide mode sets the lock, and a read of the lower byte clears it.
- The overrun flag stays set until a lower-byte read.
- In 8-bit mode every completion reaches the lower byte.

Only the bench's scenarios can show the end-to-end effects. These are the byte formatting over all 1024 result codes, that a discarded value never shows up later, and the ordering when a release and a completion fall in the same cycle. The long mixed-stimulus sweep is also what exercises mode changes while a lock is held.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;

  localparam int unsigned RES_W  = 10;
  localparam int unsigned BYTE_W = 8;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic load;     // capture the new conversion result
    logic dropped;  // a completion was discarded under the lock
  } ctrlStrobes_t;

endpackage

// File: rtl/adc_result_ctrl.sv
module adc_result_ctrl
  import adc_result_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         convDone,
  input  logic         wideMode,
  input  logic         rdHigh,
  input  logic         rdLow,
  output ctrlStrobes_t strobes,
  output logic         overrun
);

  logic lockQ;
  logic lockNext;
  logic overrunQ;
  logic overrunNext;
  logic dropNow;

  // A release in the same cycle wins over a pending lock, and 8-bit mode never locks.
  always_comb begin
    dropNow        = convDone && lockQ && wideMode && !rdLow;
    strobes.dropped = dropNow;
    strobes.load    = convDone && !dropNow;
    lockNext        = wideMode && !rdLow && (lockQ || rdHigh);
    if (rdLow) overrunNext = 1'b0;
    else       overrunNext = overrunQ || dropNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ    <= 1'b0;
      overrunQ <= 1'b0;
    end else begin
      lockQ    <= lockNext;
      overrunQ <= overrunNext;
    end
  end

  assign overrun = overrunQ;

  // R2: upper-byte read in wide mode sets the lock
  a_r2_arm_lock: assert property (@(posedge clk) disable iff (!rstN)
    (wideMode && rdHigh && !rdLow) |=> lockQ);

  // R4: lower-byte read always releases
  a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
    rdLow |=> !lockQ);

  // R5: no lock survives a cycle in 8-bit mode
  a_r5_narrow_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !wideMode |=> !lockQ);

  // R6: overrun is sticky until a lower-byte read
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrunQ && !rdLow) |=> overrunQ);

  // R6: a discard raises overrun
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && lockQ && wideMode && !rdLow) |=> overrunQ);

endmodule

// File: rtl/adc_result_data.sv
module adc_result_data
  import adc_result_pkg::*;
#(
  parameter int unsigned RW = RES_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [RW-1:0] convData,
  input  logic          wideMode,
  output logic [BW-1:0] highByte,
  output logic [BW-1:0] lowByte
);

  localparam int unsigned HI_BITS = RW - BW;   // result bits above the low byte
  localparam int unsigned PAD_W   = BW - HI_BITS;

  logic [RW-1:0] resQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             resQ <= '0;
    else if (strobes.load) resQ <= convData;
  end

  // Byte views: wide mode splits the result; narrow mode keeps the top bits only.
  always_comb begin
    if (wideMode) begin
      highByte = {{PAD_W{1'b0}}, resQ[RW-1:BW]};
      lowByte  = resQ[BW-1:0];
    end else begin
      highByte = '0;
      lowByte  = resQ[RW-1:HI_BITS];
    end
  end

  // R1: a load captures exactly the presented data
  a_r1_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (resQ == $past(convData)));

  // R3: without a load the held result does not move
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(resQ));

endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_result_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       convDone,
  input  logic [9:0] convData,
  input  logic       wideMode,
  input  logic       rdHigh,
  input  logic       rdLow,
  output logic [7:0] highByte,
  output logic [7:0] lowByte,
  output logic       overrun
);

  ctrlStrobes_t strobes;

  adc_result_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .convDone (convDone),
    .wideMode (wideMode),
    .rdHigh   (rdHigh),
    .rdLow    (rdLow),
    .strobes  (strobes),
    .overrun  (overrun)
  );

  adc_result_data #(.RW(RES_W), .BW(BYTE_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .convData (convData),
    .wideMode (wideMode),
    .highByte (highByte),
    .lowByte  (lowByte)
  );

  // R5: in 8-bit mode each completion reaches the lower byte
  a_r5_narrow_transfer: assert property (@(posedge clk) disable iff (!rstN)
    (!wideMode && convDone) |=> (wideMode || lowByte == $past(convData[9:2])));

  // R9: the upper byte is blank in 8-bit mode
  a_r9_narrow_high: assert property (@(posedge clk) disable iff (!rstN)
    !wideMode |-> (highByte == 8'h00));

endmodule

// File: tb/sim_adc_result_hold.sv
module sim_adc_result_hold;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convDone = 1'b0;
  logic [9:0] convData = '0;
  logic       wideMode = 1'b1;
  logic       rdHigh = 1'b0;
  logic       rdLow = 1'b0;
  logic [7:0] highByte;
  logic [7:0] lowByte;
  logic       overrun;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;

  // bench reference state, built from the requirements
  logic [9:0] mRes  = '0;
  logic       mLock = 1'b0;
  logic       mOvr  = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;   // 250 MHz

  adc_result_hold u0 (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
    .wideMode(wideMode), .rdHigh(rdHigh), .rdLow(rdLow),
    .highByte(highByte), .lowByte(lowByte), .overrun(overrun)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expHigh(input logic [9:0] r, input logic w);
    return w ? {6'b0, r[9:8]} : 8'h00;
  endfunction

  function automatic logic [7:0] expLow(input logic [9:0] r, input logic w);
    return w ? r[7:0] : r[9:2];
  endfunction

  // compare all outputs with the reference; tag names the requirement
  task automatic checkAll(input string tag);
    check({tag, " high"}, {2'b0, highByte}, {2'b0, expHigh(mRes, wideMode)});
    check({tag, " low"},  {2'b0, lowByte},  {2'b0, expLow(mRes, wideMode)});
    check({tag, " ovr"},  {9'b0, overrun},  {9'b0, mOvr});
  endtask

  // called at a falling edge: drive, clock, update the reference, sample at the next falling edge
  task automatic step(input logic d, input logic [9:0] data, input logic w,
                      input logic hi, input logic lo, input string tag);
    logic drop;
    convDone = d; convData = data; wideMode = w; rdHigh = hi; rdLow = lo;
    @(posedge clk);
    drop = d && mLock && w && !lo;
    if (d && !drop) mRes = data;
    mOvr  = lo ? 1'b0 : (mOvr || drop);
    mLock = w && !lo && (mLock || hi);
    @(negedge clk);
    convDone = 1'b0; rdHigh = 1'b0; rdLow = 1'b0;
    checkAll(tag);
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R10 reset");
    rstN = 1'b1;
    @(negedge clk);

    // R1, R8: every code in 10-bit mode, loaded then read high then low
    for (int v = 0; v < 1024; v++) begin
      step(1'b1, 10'(v), 1'b1, 1'b0, 1'b0, "R1 R8 load");
      step(1'b0, '0, 1'b1, 1'b1, 1'b0, "R8 read high");
      step(1'b0, '0, 1'b1, 1'b0, 1'b1, "R8 read low");
    end

    // R9: every code in 8-bit mode
    for (int v = 0; v < 1024; v++)
      step(1'b1, 10'(v), 1'b0, 1'b0, 1'b0, "R9 narrow format");

    // R2, R3, R6: lock, then a completion is dropped
    step(1'b1, 10'h155, 1'b1, 1'b0, 1'b0, "R1 load");
    step(1'b0, '0, 1'b1, 1'b1, 1'b0, "R2 arm");
    step(1'b1, 10'h2AA, 1'b1, 1'b0, 1'b0, "R3 drop");
    check("R3 held low", {2'b0, lowByte}, 10'h055);
    check("R6 overrun set", {9'b0, overrun}, 10'd1);
    step(1'b1, 10'h0F0, 1'b1, 1'b0, 1'b0, "R3 drop again");
    check("R6 sticky", {9'b0, overrun}, 10'd1);
    // R7: release and completion together load the new value, clear overrun
    step(1'b1, 10'h3C3, 1'b1, 1'b0, 1'b1, "R7 release+load");
    check("R7 new low", {2'b0, lowByte}, 10'h0C3);
    check("R6 cleared", {9'b0, overrun}, 10'd0);
    // R4: read high and low together leaves it unlocked
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, "R4 both reads");
    step(1'b1, 10'h011, 1'b1, 1'b0, 1'b0, "R4 unlocked load");
    check("R4 load after release", {2'b0, lowByte}, 10'h011);
    // R5: narrow mode ignores a high read
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R5 high read narrow");
    step(1'b1, 10'h3FC, 1'b0, 1'b0, 1'b0, "R5 narrow load");
    check("R5 transfer", {2'b0, lowByte}, 10'h0FF);
    check("R5 no overrun", {9'b0, overrun}, 10'd0);

    // mixed sweep over all strobe combinations with pseudo-random data
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[15:6], (i % 500) < 430, lfsr[1] & lfsr[2],
           lfsr[3] & lfsr[4] & lfsr[5], "R1 R3 R4 R5 R6 R7 sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule